// File: doc/BRIEF.md
# Serial Device Identifier Responder

This block supplies the data phase of the read-identifier command on an SPI target that runs in SPI mode 0 or mode 3. The command decoder, which shifts in the op-code 0x9F, issues a one-cycle start strobe once the op-code is complete. From then on the responder drives a fixed 32-bit identifier onto the serial output, one bit on each SCK falling edge. The bytes go out in this order: manufacturer code, continuation code, first product byte, second product byte. Each byte is sent MSB first. The four bytes are parameters, and their defaults are 0x04, 0x7F, 0xAA and 0x03.

The block runs on a fast system clock. It takes a chip-select level that is already synchronised, plus a one-cycle strobe for each SCK falling edge. After the 32nd bit the output stays at that last bit for any further SCK edges. Raising chip select floats the output and clears the bit position. A start that arrives while a write is in progress is refused, and the output then stays undriven for the rest of that selection.

Top module: `sid_responder`

## Requirements
- R1: While reset is held and on the first cycle after it, `so_oe` is 0 and `so` is 0.
- R2: After an accepted start, `so_oe` rises one clock after the first `sck_fall` strobe. At the same time `so` shows bit 7 of the manufacturer byte.
- R3: The k-th strobe (k = 0..31) sets `so` to bit 31-k of the word {manufacturer, continuation, product 1, product 2}, which is 0x047FAA03 by default. Each value appears one clock after its strobe.
- R4: While chip select is low, `so` changes only in the clock after an `sck_fall` strobe.
- R5: Strobes after the 32nd leave `so` at bit 0 of the second product byte with `so_oe` at 1, until chip select rises.
- R6: One clock after `cs_n` is high, `so_oe` and `so` are 0. The next accepted start sends the identifier again from its first bit.
- R7: A start that arrives while `busy` is 1 is refused, and `so_oe` stays 0 on later strobes in that selection.
- R8: A start that arrives while an identifier is already being sent is ignored, and the bit sequence carries on unchanged.
- R9: A start that arrives while `cs_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck_fall | input | 1 | One-cycle strobe marking an SCK falling edge |
| start | input | 1 | One-cycle strobe from the command decoder after op-code 0x9F |
| busy | input | 1 | Write in progress; refuses the command |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data pad |

## Verification
The main pattern is a complete identifier read, once with back-to-back strobes and many times with random gaps. The back-to-back run checks the byte and bit order. The random gaps show that the output moves only on strobes and never on idle clocks. Random read lengths that stop short of 32 bits tell a correct reset of the bit position apart from a counter that resumes where it left off. Lengths past 32 bits tell holding the last bit apart from wrapping around or floating. Directed cases send a start while busy, a start while deselected and a second start in the middle of a read; each should leave the output undriven or the sequence undisturbed.

// File: rtl/sid_pkg.sv
package sid_pkg;
  typedef enum logic [1:0] {
    SID_IDLE  = 2'd0,
    SID_ARMED = 2'd1,
    SID_SHIFT = 2'd2,
    SID_HOLD  = 2'd3
  } sid_state_t;
endpackage

// File: rtl/sid_word.sv
// Assembles the identifier word from individual bytes; slot 0 of the
// packed input lands in the most significant byte (sent first).
module sid_word #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter logic [NUM_BYTES*BYTE_W-1:0] BYTES_IN = '0
) (
  output logic [NUM_BYTES*BYTE_W-1:0] word
);
  localparam int WORD_W = NUM_BYTES * BYTE_W;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    assign word[WORD_W-1-i*BYTE_W -: BYTE_W] = BYTES_IN[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sid_seq.sv
// Bit sequencer: accepts the start strobe, counts SCK falling strobes
// and stops counting once the whole word has been issued.
module sid_seq
  import sid_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W),
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             start,
  input  logic             busy,
  input  logic             sck_fall,
  output logic             emit,
  output logic [IDX_W-1:0] bit_sel,
  output logic             clear
);
  sid_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             last_bit;

  assign last_bit = (cnt == CNT_W'(WORD_W - 1));
  assign emit     = !cs_n && sck_fall &&
                    ((state == SID_ARMED) || (state == SID_SHIFT));
  assign bit_sel  = cnt[IDX_W-1:0];
  assign clear    = cs_n;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      state <= SID_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SID_IDLE: begin
          if (start && !busy) state <= SID_ARMED;
        end
        SID_ARMED, SID_SHIFT: begin
          if (sck_fall) begin
            cnt   <= cnt + CNT_W'(1);
            state <= last_bit ? SID_HOLD : SID_SHIFT;
          end
        end
        SID_HOLD: state <= SID_HOLD;
        default:  state <= SID_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sid_out.sv
// Registered output stage: selects the addressed bit, MSB first, and
// keeps it (and the enable) until the selection ends.
module sid_out #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              emit,
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  bit_sel,
  output logic              so,
  output logic              so_oe
);
  logic [IDX_W-1:0] pos;

  assign pos = IDX_W'(WORD_W - 1) - bit_sel;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (emit) begin
      so    <= word[pos];
      so_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/sid_responder.sv
module sid_responder #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h04,
  parameter logic [BYTE_W-1:0] CONT_CODE = 8'h7F,
  parameter logic [BYTE_W-1:0] PROD_HI   = 8'hAA,
  parameter logic [BYTE_W-1:0] PROD_LO   = 8'h03
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck_fall,
  input  logic start,
  input  logic busy,
  output logic so,
  output logic so_oe
);
  localparam int NUM_BYTES = 4;
  localparam int WORD_W    = NUM_BYTES * BYTE_W;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] PACKED = {PROD_LO, PROD_HI, CONT_CODE, MFR_CODE};

  logic [WORD_W-1:0] id_word;
  logic              emit;
  logic              clear;
  logic [IDX_W-1:0]  bit_sel;

  sid_word #(
    .BYTE_W   (BYTE_W),
    .NUM_BYTES(NUM_BYTES),
    .BYTES_IN (PACKED)
  ) u_word (
    .word(id_word)
  );

  sid_seq #(
    .WORD_W(WORD_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .start   (start),
    .busy    (busy),
    .sck_fall(sck_fall),
    .emit    (emit),
    .bit_sel (bit_sel),
    .clear   (clear)
  );

  sid_out #(
    .WORD_W(WORD_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .emit   (emit),
    .word   (id_word),
    .bit_sel(bit_sel),
    .so     (so),
    .so_oe  (so_oe)
  );
endmodule

// File: rtl/sid_responder_chk.sv
module sid_responder_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck_fall,
  input logic so,
  input logic so_oe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!so_oe && !so));

  // R2
  oe_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> $past(sck_fall));

  // R4
  so_hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !sck_fall) |=> $stable(so));

  // R6
  float_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!so_oe && !so));

  // R5
  oe_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (so_oe && !cs_n) |=> so_oe);
endmodule

bind sid_responder sid_responder_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .sck_fall(sck_fall),
  .so      (so),
  .so_oe   (so_oe)
);

// File: tb/sid_responder_test.sv
module sid_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_WORD = 32'h047FAA03;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck_fall = 1'b0;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic so, so_oe;
  int   total = 0;
  int   bad = 0;

  sid_responder uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_fall(sck_fall),
    .start(start), .busy(busy), .so(so), .so_oe(so_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_bit(int k);
    return (k < 32) ? ID_WORD[31-k] : ID_WORD[0];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe();
    @(negedge clk) sck_fall = 1'b1;
    @(negedge clk) sck_fall = 1'b0;
  endtask

  task automatic begin_cmd(logic b);
    @(negedge clk);
    cs_n = 1'b0; busy = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; busy = 1'b0;
  endtask

  task automatic end_cmd();
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R6 oe", so_oe, 1'b0);
    chk("R6 so", so, 1'b0);
  endtask

  task automatic read_bits(int from, int n, int max_gap);
    for (int k = from; k < from + n; k++) begin
      strobe();
      chk("R3 bit", so, exp_bit(k));
      chk("R5 oe", so_oe, 1'b1);
      if (max_gap > 0) begin
        int g = $urandom_range(max_gap, 0);
        repeat (g) @(negedge clk);
        chk("R4 stable", so, exp_bit(k));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", so_oe, 1'b0);
    chk("R1 so in reset", so, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", so_oe, 1'b0);
    chk("R1 so after reset", so, 1'b0);

    // R2 R3 R5: full read, back-to-back, then overrun
    begin_cmd(1'b0);
    chk("R2 oe before strobe", so_oe, 1'b0);
    strobe();
    chk("R2 first bit", so, exp_bit(0));
    chk("R2 oe", so_oe, 1'b1);
    read_bits(1, 31, 0);
    for (int e = 0; e < 5; e++) begin
      strobe();
      chk("R5 hold last", so, 1'b1);
      chk("R5 oe kept", so_oe, 1'b1);
    end
    end_cmd();

    // R7: start refused while busy
    begin_cmd(1'b1);
    repeat (4) strobe();
    chk("R7 oe stays off", so_oe, 1'b0);
    end_cmd();

    // R9: start while deselected
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin start = 1'b0; cs_n = 1'b0; end
    repeat (3) strobe();
    chk("R9 oe stays off", so_oe, 1'b0);
    end_cmd();

    // R8: second start mid-read
    begin_cmd(1'b0);
    read_bits(0, 5, 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    strobe();
    chk("R8 continues", so, exp_bit(5));
    read_bits(6, 26, 0);
    end_cmd();

    // R6: abort then restart from the first bit
    begin_cmd(1'b0);
    read_bits(0, 10, 1);
    end_cmd();
    begin_cmd(1'b0);
    strobe();
    chk("R6 restart bit0", so, exp_bit(0));
    end_cmd();

    // random lengths and gaps
    for (int it = 0; it < 25; it++) begin
      int len = $urandom_range(40, 1);
      begin_cmd(1'b0);
      read_bits(0, len, 3);
      end_cmd();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule